// File: doc/BRIEF.md
# Digital potentiometer wiper controller

This block is the control logic for a digitally trimmed potentiometer. A host drives it through three asynchronous wires: an active-low select, an increment strobe and a direction level. While the block is selected, each falling edge of the strobe moves a wiper counter one tap up or down. The counter stops at the first and last tap and does not wrap. The counter feeds a one-hot tap-select bus, which drives the switches of an external resistor ladder.

The level of the strobe at the moment select is released decides what happens to the position. If the strobe is high, the position is committed to a modelled nonvolatile cell. A store-busy period of programmable length follows, and reselection is refused until it ends. If the strobe is low, the position is kept in the counter only, and the cell is left alone. After every reset the cell is recalled into the counter before any movement is accepted. The tap bus stays dark until that recall is done.

All three host wires pass through synchronisers into the system clock domain. Strobe edges are detected on the synchronised level.

Top module: `digipot_wiper_ctrl`

## Requirements
- R1: While select is high, and throughout a store-busy period, strobe edges leave `wiper_o` unchanged.
- R2: While selected, each high-to-low strobe transition moves `wiper_o` by exactly one. `up_i`=1 increments and `up_i`=0 decrements. The direction may change between steps within one selection.
- R3: Stepping down at 0 leaves 0, and stepping up at TAPS-1 leaves TAPS-1. The counter never wraps.
- R4: Outside reset and recall, `tap_sel_o` has exactly one bit set, and that bit's index equals `wiper_o`.
- R5: Releasing select while the strobe is high stores `wiper_o` in the nonvolatile cell. `store_busy_o` is then high for max(`store_cycles_i`,1) consecutive cycles, after which `standby_o` rises.
- R6: Releasing select while the strobe is low starts no store: `store_busy_o` stays low, the cell keeps its old value, `wiper_o` keeps its position and `standby_o` rises.
- R7: During reset, `tap_sel_o`, `store_busy_o` and `standby_o` are all zero. After reset the last stored value (NV_INIT if nothing was ever stored) is loaded into `wiper_o` and `standby_o` rises.
- R8: A select driven low during store-busy is not acted upon until the busy period ends. If select is still low at that point, the block becomes selected and `standby_o` falls.
- R9: If select rises in the same synchronised cycle as a strobe falling edge, the wiper does not step and no store takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| sel_ni | input | 1 | Active-low select, asynchronous |
| step_i | input | 1 | Increment strobe, falling edge active, asynchronous |
| up_i | input | 1 | Direction: 1 up, 0 down, asynchronous |
| store_cycles_i | input | DLY_W | Store-busy length in clock cycles (0 treated as 1) |
| tap_sel_o | output | TAPS | One-hot tap select |
| wiper_o | output | $clog2(TAPS) | Current wiper position |
| store_busy_o | output | 1 | High while a store is in progress |
| standby_o | output | 1 | High while deselected and idle |

## Verification
The delicate coincidence is a strobe falling edge that lands in the same synchronised cycle as the release of select. The release wins, so no step is taken. Because the strobe is then low, no store is taken either. The bench provokes this by driving both wires at the same clock edge, so the two synchronisers carry them side by side. It then checks that the wiper is unchanged, that busy never rose and that standby is set. A second overlap is reselection with strobe pulses inside a store-busy window. The bench judges it by an unchanged wiper after busy ends and by the block turning active without a new select edge.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  typedef enum logic [1:0] {
    ST_RECALL  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_STORE   = 2'd3
  } dp_state_e;
endpackage

// File: rtl/digipot_sync.sv
module digipot_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/digipot_counter.sv
module digipot_counter #(
  parameter int TAPS = 32,
  localparam int W   = $clog2(TAPS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         up_i,
  output logic [W-1:0] pos_o
);
  localparam logic [W-1:0] TOP = W'(TAPS - 1);

  logic [W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (load_i) begin
      pos_q <= (load_val_i > TOP) ? TOP : load_val_i;
    end else if (step_i) begin
      if (up_i && pos_q != TOP)       pos_q <= pos_q + 1'b1;
      else if (!up_i && pos_q != '0)  pos_q <= pos_q - 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/digipot_decode.sv
module digipot_decode #(
  parameter int TAPS = 32,
  localparam int W   = $clog2(TAPS)
) (
  input  logic            en_i,
  input  logic [W-1:0]    pos_i,
  output logic [TAPS-1:0] tap_o
);
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap_o[t] = en_i && (pos_i == W'(t));
    end
  endgenerate
endmodule

// File: rtl/digipot_seq.sv
module digipot_seq
  import digipot_pkg::*;
#(
  parameter int TAPS    = 32,
  parameter int DLY_W   = 24,
  parameter int NV_INIT = TAPS / 2,
  localparam int W      = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_n_s_i,
  input  logic             strobe_s_i,
  input  logic [DLY_W-1:0] store_cycles_i,
  input  logic [W-1:0]     pos_i,
  output dp_state_e        state_o,
  output logic             step_o,
  output logic             load_o,
  output logic [W-1:0]     nv_o
);
  dp_state_e        st_q, st_d;
  logic             strobe_d_q;
  logic             strobe_fall;
  logic [DLY_W-1:0] timer_q, timer_d;
  logic             nv_wr;
  // Stand-in for the nonvolatile cell: no reset, survives rst_ni.
  logic [W-1:0]     nv_q = W'(NV_INIT);

  assign strobe_fall = strobe_d_q && !strobe_s_i;

  always_comb begin
    st_d    = st_q;
    timer_d = timer_q;
    nv_wr   = 1'b0;
    step_o  = 1'b0;
    load_o  = 1'b0;
    unique case (st_q)
      ST_RECALL: begin
        load_o = 1'b1;
        st_d   = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (!sel_n_s_i) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (sel_n_s_i) begin
          // release wins over a coincident strobe edge
          if (strobe_s_i) begin
            st_d    = ST_STORE;
            timer_d = (store_cycles_i == '0) ? DLY_W'(1) : store_cycles_i;
          end else begin
            st_d = ST_STANDBY;
          end
        end else if (strobe_fall) begin
          step_o = 1'b1;
        end
      end
      ST_STORE: begin
        if (timer_q == DLY_W'(1)) begin
          nv_wr = 1'b1;
          st_d  = ST_STANDBY;
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      default: st_d = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RECALL;
      timer_q    <= '0;
      strobe_d_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      timer_q    <= timer_d;
      strobe_d_q <= strobe_s_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (nv_wr) nv_q <= pos_i;
  end

  assign state_o = st_q;
  assign nv_o    = nv_q;
endmodule

// File: rtl/digipot_wiper_ctrl.sv
module digipot_wiper_ctrl
  import digipot_pkg::*;
#(
  parameter int TAPS        = 32,
  parameter int DLY_W       = 24,
  parameter int NV_INIT     = TAPS / 2,
  parameter int SYNC_STAGES = 2,
  localparam int W          = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [DLY_W-1:0] store_cycles_i,
  output logic [TAPS-1:0]  tap_sel_o,
  output logic [W-1:0]     wiper_o,
  output logic             store_busy_o,
  output logic             standby_o
);
  logic [2:0] raw, synced;
  logic       sel_n_s, strobe_s, up_s;
  dp_state_e  st;
  logic       step_en, load_en;
  logic [W-1:0] nv_val;

  assign raw = {sel_ni, step_i, up_i};

  digipot_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {sel_n_s, strobe_s, up_s} = synced;

  digipot_seq #(
    .TAPS   (TAPS),
    .DLY_W  (DLY_W),
    .NV_INIT(NV_INIT)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_n_s_i     (sel_n_s),
    .strobe_s_i    (strobe_s),
    .store_cycles_i(store_cycles_i),
    .pos_i         (wiper_o),
    .state_o       (st),
    .step_o        (step_en),
    .load_o        (load_en),
    .nv_o          (nv_val)
  );

  digipot_counter #(.TAPS(TAPS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_en),
    .load_val_i(nv_val),
    .step_i    (step_en),
    .up_i      (up_s),
    .pos_o     (wiper_o)
  );

  digipot_decode #(.TAPS(TAPS)) u_dec (
    .en_i (rst_ni && st != ST_RECALL),
    .pos_i(wiper_o),
    .tap_o(tap_sel_o)
  );

  assign store_busy_o = (st == ST_STORE);
  assign standby_o    = (st == ST_STANDBY);
endmodule

// File: rtl/digipot_wiper_ctrl_chk.sv
module digipot_wiper_ctrl_chk
  import digipot_pkg::*;
#(
  parameter int TAPS = 32,
  localparam int W   = $clog2(TAPS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input dp_state_e       st,
  input logic [W-1:0]    wiper_o,
  input logic [TAPS-1:0] tap_sel_o,
  input logic [W-1:0]    nv_val
);
  localparam logic [W-1:0] TOP = W'(TAPS - 1);

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) != ST_ACTIVE && $past(st) != ST_RECALL) |-> $stable(wiper_o));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) == ST_ACTIVE) |->
      (wiper_o == $past(wiper_o) || wiper_o == $past(wiper_o) + W'(1) ||
       wiper_o + W'(1) == $past(wiper_o)));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) != ST_RECALL && $past(wiper_o) == TOP) |-> wiper_o != '0);

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) != ST_RECALL && $past(wiper_o) == '0) |-> wiper_o != TOP);

  a_r4_one_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_RECALL) |-> ($countones(tap_sel_o) == 1 && tap_sel_o[wiper_o]));

  a_r5_nv_write_in_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) != ST_STORE) |-> $stable(nv_val));

  a_r7_dark_in_recall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RECALL) |-> tap_sel_o == '0);
endmodule

bind digipot_wiper_ctrl digipot_wiper_ctrl_chk #(.TAPS(TAPS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .st       (st),
  .wiper_o  (wiper_o),
  .tap_sel_o(tap_sel_o),
  .nv_val   (nv_val)
);

// File: tb/digipot_wiper_ctrl_bench.sv
module digipot_wiper_ctrl_bench;
  localparam int TAPS  = 32;
  localparam int W     = $clog2(TAPS);
  localparam int DLY_W = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ni = 1'b1, step_i = 1'b1, up_i = 1'b0;
  logic [DLY_W-1:0] store_cycles_i = '0;
  logic [TAPS-1:0] tap_sel_o;
  logic [W-1:0] wiper_o;
  logic store_busy_o, standby_o;

  int total = 0, bad = 0;
  int exp_w, exp_nv;
  bit selected = 0;

  always #5 clk = ~clk;

  digipot_wiper_ctrl u_digipot_wiper_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .step_i(step_i), .up_i(up_i),
    .store_cycles_i(store_cycles_i), .tap_sel_o(tap_sel_o), .wiper_o(wiper_o),
    .store_busy_o(store_busy_o), .standby_o(standby_o)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat_step(int p, bit up);
    if (up) return (p == TAPS - 1) ? p : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  function automatic longint onehot(int p);
    return longint'(1) << p;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pos(string req);
    chk(wiper_o == W'(exp_w), req, wiper_o, exp_w);
    chk(tap_sel_o == TAPS'(onehot(exp_w)), "R4", tap_sel_o, onehot(exp_w));
  endtask

  task automatic do_select();
    sel_ni = 1'b0;
    cyc(5);
    chk(standby_o == 1'b0, "R7 standby falls on select", standby_o, 0);
    selected = 1;
  endtask

  task automatic do_pulse(bit dir);
    up_i = dir;
    cyc(3);
    step_i = 1'b0;
    cyc(3);
    step_i = 1'b1;
    cyc(3);
    exp_w = sat_step(exp_w, dir);
  endtask

  task automatic do_store(int n);
    int cnt = 0;
    int want = (n == 0) ? 1 : n;
    store_cycles_i = DLY_W'(n);
    sel_ni = 1'b1;
    for (int i = 0; i < n + 40; i++) begin
      @(negedge clk);
      if (store_busy_o) cnt++;
      else if (cnt > 0) break;
    end
    chk(cnt == want, "R5 busy length", cnt, want);
    chk(standby_o == 1'b1, "R5 standby after store", standby_o, 1);
    check_pos("R5");
    exp_nv = exp_w;
    selected = 0;
  endtask

  task automatic do_discard(bit dir);
    int busy_seen = 0;
    up_i = dir;
    cyc(3);
    step_i = 1'b0;
    cyc(4);
    exp_w = sat_step(exp_w, dir);
    sel_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (store_busy_o) busy_seen++;
    end
    chk(busy_seen == 0, "R6 no busy", busy_seen, 0);
    chk(standby_o == 1'b1, "R6 standby", standby_o, 1);
    check_pos("R6");
    step_i = 1'b1;
    cyc(4);
    check_pos("R1 rising strobe while deselected");
    selected = 0;
  endtask

  task automatic do_power_cycle();
    rst_ni = 1'b0;
    cyc(2);
    chk(tap_sel_o == '0, "R7 taps dark in reset", tap_sel_o, 0);
    chk(store_busy_o == 1'b0 && standby_o == 1'b0, "R7 flags in reset",
        {store_busy_o, standby_o}, 0);
    sel_ni = 1'b1;
    step_i = 1'b1;
    rst_ni = 1'b1;
    cyc(3);
    exp_w = exp_nv;
    check_pos("R7 recall");
    chk(standby_o == 1'b1, "R7 standby after recall", standby_o, 1);
    selected = 0;
  endtask

  task automatic do_coincide();
    int busy_seen = 0;
    sel_ni = 1'b1;
    step_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (store_busy_o) busy_seen++;
    end
    chk(busy_seen == 0, "R9 no store on coincidence", busy_seen, 0);
    chk(standby_o == 1'b1, "R9 standby", standby_o, 1);
    check_pos("R9 no step on coincidence");
    step_i = 1'b1;
    cyc(4);
    selected = 0;
  endtask

  task automatic do_reselect_in_busy();
    int cnt = 0;
    store_cycles_i = DLY_W'(30);
    sel_ni = 1'b1;
    cyc(5);
    chk(store_busy_o == 1'b1, "R8 busy started", store_busy_o, 1);
    sel_ni = 1'b0;
    up_i = (exp_w < TAPS / 2);
    step_i = 1'b0;
    cyc(3);
    step_i = 1'b1;
    cyc(2);
    check_pos("R1 strobe in busy ignored");
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!store_busy_o) break;
      cnt++;
    end
    cyc(2);
    check_pos("R8 wiper after busy");
    chk(standby_o == 1'b0, "R8 active after busy", standby_o, 0);
    exp_nv = exp_w;
    selected = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd9314);
    exp_nv = TAPS / 2;
    cyc(3);
    do_power_cycle();

    // strobe edges while deselected
    do_pulse(1'b1);
    exp_w = exp_nv;
    check_pos("R1 deselected strobe ignored");

    do_select();
    for (int i = 0; i < TAPS + 4; i++) do_pulse(1'b0);
    check_pos("R3 floor at zero");
    for (int i = 0; i < 3; i++) do_pulse(1'b1);
    do_pulse(1'b0);
    check_pos("R2 direction change in one selection");
    for (int i = 0; i < TAPS + 4; i++) do_pulse(1'b1);
    check_pos("R3 ceiling at top");

    do_store(0);
    do_select();
    for (int i = 0; i < 5; i++) do_pulse(1'b0);
    do_reselect_in_busy();
    do_pulse(1'b0);
    do_discard(1'b0);
    do_power_cycle();
    do_select();
    do_pulse(1'b1);
    do_coincide();
    do_select();
    do_store(7);
    do_power_cycle();

    for (int op = 0; op < 150; op++) begin
      int r = $urandom % 16;
      if (r <= 10) begin
        int k = 1 + $urandom % 8;
        bit d = $urandom % 2;
        if (!selected) do_select();
        for (int j = 0; j < k; j++) do_pulse(d);
        check_pos("R2 random steps");
      end else if (r <= 12) begin
        if (!selected) do_select();
        do_store($urandom % 40);
      end else if (r == 13) begin
        if (!selected) do_select();
        do_discard($urandom % 2);
      end else if (r == 14) begin
        do_power_cycle();
      end else begin
        if (!selected) do_select();
        do_coincide();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule